// File: doc/BRIEF.md
# Set-Associative Word Cache with Block Refill

This block sits between a processor port that reads and writes single 32-bit words and a memory port that delivers whole 16-byte blocks. The storage is organized as 2^SET_BITS sets, each holding WAYS lines. Every line has a valid flag, a tag and four data words. A request is accepted only while the controller is idle, and the controller handles one request at a time. A read that finds its block returns the word on the next cycle. A read that does not find its block fetches the whole block from memory, installs it in a chosen line and then answers. Writes always go to memory. A write also updates the cached copy when the block is present, and it never allocates a line.

The controller has four named states. IDLE accepts requests and serves read hits. MEM_REQ holds a block read request until memory takes it. FILL collects four data beats. WR_THRU holds a single-word write request until memory takes it. The transitions are:
- IDLE→IDLE on a read hit or when no request is present.
- IDLE→MEM_REQ on a read miss.
- IDLE→WR_THRU on any write.
- MEM_REQ→FILL on the memory handshake.
- FILL→IDLE after the fourth beat.
- WR_THRU→IDLE on the memory handshake.

Setting WAYS=1 gives a direct-mapped cache. Setting WAYS=2 gives a two-way cache that keeps one recency bit per set.

Top module: `sa_cache`

## Requirements
- R1: An address splits, from the top down, into TAG_W tag bits, SET_BITS set-index bits and 4 offset bits. Offset bits [3:2] select the word in the block, and bits [1:0] are ignored. Because the set index comes from the middle bits, neighbouring blocks fall in different sets and can be resident together.
- R2: A read whose block is held in a valid line of its set, with a matching tag, raises cpu_resp_valid for one cycle on the cycle after acceptance. It returns the selected word and issues no memory request.
- R3: A read miss issues exactly one memory read request. It has mem_req_write=0 and its address is the block base, with bits [3:0] zero.
- R4: During a refill, cpu_req_ready stays low. The memory returns words 0,1,2,3 on beats marked by mem_rsp_valid, and gaps between beats are allowed. After the fourth beat the requested word is returned with a one-cycle cpu_resp_valid.
- R5: A line becomes valid only once all four beats have arrived. After that, every word of the block hits.
- R6: A memory request (mem_req_valid) stays asserted, with its address and direction unchanged, until mem_req_ready is seen high.
- R7: Every write issues one memory word write with mem_req_write=1, the word-aligned address and the write data. The write is acknowledged by cpu_resp_valid after the handshake.
- R8: A write hit also replaces the cached word, so a later read of that word hits and returns the new data.
- R9: A write miss issues no block read and installs nothing, so a later read of that block misses.
- R10: With WAYS=2, a fill uses an invalid line of the set first. If both lines are valid, the fill evicts the line used less recently, where both hits and fills count as uses. At most one line of a set ever matches.
- R11: With WAYS=1, a block evicts whatever block previously occupied its set.
- R12: Reset clears every valid flag and leaves the block idle: cpu_req_ready=1, cpu_resp_valid=0, mem_req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller idle, request taken this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | 32 | Write word |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | 32 | Read word, valid with the pulse on reads |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = word write, 0 = block read |
| mem_req_addr | output | ADDR_W | Block base (read) or word address (write) |
| mem_req_wdata | output | 32 | Word to write |
| mem_rsp_valid | input | 1 | Refill beat present |
| mem_rsp_data | input | 32 | Refill word |

## Verification
The bench builds two copies side by side from one request stream, both with ADDR_W=12 and two lines of storage. One copy uses SET_BITS=1 and WAYS=1, which is direct-mapped. The other uses SET_BITS=0 and WAYS=2, a single two-line set. The same accesses therefore hit in one copy and miss in the other, which brings conflict eviction in the direct-mapped copy and recency-based choice in the two-way copy into view under identical traffic. The memory model pauses its ready signal and leaves gaps between refill beats, so held requests and gapped refills are both exercised.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 4;
    localparam int WSEL_W    = 2;
    localparam int OFF_BITS  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM_REQ,
        ST_FILL,
        ST_WR_THRU
    } cache_state_t;
endpackage

// File: rtl/cache_tags.sv
module cache_tags
    import cache_pkg::*;
#(
    parameter int WAYS  = 1,
    parameter int ROWS  = 2,
    parameter int IDX_W = 1,
    parameter int TAG_W = 7,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [WAYS-1:0]  hit_way,
    output logic             lk_hit,
    output logic [WAY_W-1:0] hit_idx,
    input  logic [IDX_W-1:0] fl_idx,
    output logic [WAY_W-1:0] victim,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [WAY_W-1:0] touch_way
);
    logic [WAYS-1:0] way_full;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic             vld_r [ROWS];
        logic [TAG_W-1:0] tag_r [ROWS];
        logic             sel;

        assign sel = fill_en && (victim == WAY_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int r = 0; r < ROWS; r++) vld_r[r] <= 1'b0;
            end else if (sel) begin
                vld_r[fl_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) tag_r[fl_idx] <= fill_tag;
        end

        assign hit_way[w]  = vld_r[lk_idx] && (tag_r[lk_idx] == lk_tag);
        assign way_full[w] = vld_r[fl_idx];
    end

    assign lk_hit = |hit_way;

    always_comb begin
        hit_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_way[w]) hit_idx = WAY_W'(w);
        end
    end

    if (WAYS == 2) begin : g_lru
        logic lru_r [ROWS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int r = 0; r < ROWS; r++) lru_r[r] <= 1'b0;
            end else if (touch_en) begin
                lru_r[touch_idx] <= ~touch_way[0];
            end
        end

        always_comb begin
            if (!way_full[0])      victim = WAY_W'(0);
            else if (!way_full[1]) victim = WAY_W'(1);
            else                   victim = WAY_W'(lru_r[fl_idx]);
        end
    end else begin : g_direct
        logic unused_touch;
        assign unused_touch = ^{touch_en, touch_idx, touch_way, way_full};
        assign victim = '0;
    end
endmodule

// File: rtl/cache_data.sv
module cache_data
    import cache_pkg::*;
#(
    parameter int WAYS  = 1,
    parameter int ROWS  = 2,
    parameter int IDX_W = 1,
    parameter int WAY_W = 1
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data
);
    localparam int DEPTH = ROWS * WAYS * BLK_WORDS;
    localparam int PTR_W = $clog2(DEPTH);

    logic [WORD_W-1:0] words_r [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;

    assign rd_ptr = PTR_W'((int'(rd_idx) * WAYS + int'(rd_way)) * BLK_WORDS + int'(rd_word));
    assign wr_ptr = PTR_W'((int'(wr_idx) * WAYS + int'(wr_way)) * BLK_WORDS + int'(wr_word));

    assign rd_data = words_r[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_en) words_r[wr_ptr] <= wr_data;
    end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic              lk_hit,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    output logic              cpu_req_ready,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic              accept,
    output logic              write_hit,
    output logic              fill_beat,
    output logic              fill_last,
    output logic              resp_set,
    output logic [WSEL_W-1:0] beat_q
);
    cache_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         beat_q <= '0;
        else if (fill_beat) beat_q <= beat_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req_valid && cpu_req_write) state_d = ST_WR_THRU;
                else if (cpu_req_valid && !lk_hit)  state_d = ST_MEM_REQ;
            end
            ST_MEM_REQ: if (mem_req_ready) state_d = ST_FILL;
            ST_FILL:    if (fill_last)     state_d = ST_IDLE;
            ST_WR_THRU: if (mem_req_ready) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_req_ready = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        accept        = 1'b0;
        write_hit     = 1'b0;
        fill_beat     = 1'b0;
        fill_last     = 1'b0;
        resp_set      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cpu_req_ready = 1'b1;
                accept        = cpu_req_valid;
                write_hit     = cpu_req_valid && cpu_req_write && lk_hit;
                resp_set      = cpu_req_valid && !cpu_req_write && lk_hit;
            end
            ST_MEM_REQ: mem_req_valid = 1'b1;
            ST_FILL: begin
                fill_beat = mem_rsp_valid;
                fill_last = mem_rsp_valid && (beat_q == WSEL_W'(BLK_WORDS - 1));
                resp_set  = fill_last;
            end
            ST_WR_THRU: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                resp_set      = mem_req_ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sa_cache.sv
module sa_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int SET_BITS = 1,
    parameter int WAYS     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [WORD_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [WORD_W-1:0] cpu_resp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data
);
    localparam int IDX_W = (SET_BITS > 0) ? SET_BITS : 1;
    localparam int ROWS  = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - SET_BITS - OFF_BITS;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [IDX_W-1:0]  cpu_idx, lat_idx, touch_idx;
    logic [TAG_W-1:0]  cpu_tag, lat_tag;
    logic [WSEL_W-1:0] cpu_word, lat_word, beat_q, wr_word;
    logic [ADDR_W-3:0] lat_waddr;
    logic [WORD_W-1:0] lat_wdata, rd_data, wr_data;
    logic [WAYS-1:0]   hit_way;
    logic [WAY_W-1:0]  hit_idx, victim, wr_way, touch_way;
    logic              lk_hit, accept, write_hit, fill_beat, fill_last, resp_set;
    logic              touch_en, unused_low;

    assign cpu_idx  = (SET_BITS > 0) ? cpu_req_addr[OFF_BITS +: IDX_W] : '0;
    assign cpu_tag  = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign cpu_word = cpu_req_addr[3:2];
    assign lat_idx  = (SET_BITS > 0) ? lat_waddr[OFF_BITS-2 +: IDX_W] : '0;
    assign lat_tag  = lat_waddr[ADDR_W-3 -: TAG_W];
    assign lat_word = lat_waddr[1:0];
    assign unused_low = ^cpu_req_addr[1:0];

    cache_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_write (cpu_req_write),
        .lk_hit        (lk_hit),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .cpu_req_ready (cpu_req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .accept        (accept),
        .write_hit     (write_hit),
        .fill_beat     (fill_beat),
        .fill_last     (fill_last),
        .resp_set      (resp_set),
        .beat_q        (beat_q)
    );

    assign touch_en  = (accept && lk_hit) || fill_last;
    assign touch_idx = fill_last ? lat_idx : cpu_idx;
    assign touch_way = fill_last ? victim : hit_idx;

    cache_tags #(
        .WAYS(WAYS), .ROWS(ROWS), .IDX_W(IDX_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (cpu_idx),
        .lk_tag    (cpu_tag),
        .hit_way   (hit_way),
        .lk_hit    (lk_hit),
        .hit_idx   (hit_idx),
        .fl_idx    (lat_idx),
        .victim    (victim),
        .fill_en   (fill_last),
        .fill_tag  (lat_tag),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .touch_way (touch_way)
    );

    assign wr_way  = fill_beat ? victim : hit_idx;
    assign wr_word = fill_beat ? beat_q : cpu_word;
    assign wr_data = fill_beat ? mem_rsp_data : cpu_req_wdata;

    cache_data #(
        .WAYS(WAYS), .ROWS(ROWS), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_data (
        .clk     (clk),
        .rd_idx  (cpu_idx),
        .rd_way  (hit_idx),
        .rd_word (cpu_word),
        .rd_data (rd_data),
        .wr_en   (write_hit || fill_beat),
        .wr_idx  (fill_beat ? lat_idx : cpu_idx),
        .wr_way  (wr_way),
        .wr_word (wr_word),
        .wr_data (wr_data)
    );

    always_ff @(posedge clk) begin
        if (accept) begin
            lat_waddr <= cpu_req_addr[ADDR_W-1:2];
            lat_wdata <= cpu_req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_resp_valid <= 1'b0;
            cpu_resp_rdata <= '0;
        end else begin
            cpu_resp_valid <= resp_set;
            if (accept && !cpu_req_write && lk_hit)
                cpu_resp_rdata <= rd_data;
            else if (fill_beat && (beat_q == lat_word))
                cpu_resp_rdata <= mem_rsp_data;
        end
    end

    assign mem_req_addr  = mem_req_write ? {lat_waddr, 2'b00}
                                         : {lat_waddr[ADDR_W-3:2], 4'b0000};
    assign mem_req_wdata = lat_wdata;
endmodule

// File: rtl/sa_cache_chk.sv
module sa_cache_chk #(
    parameter int ADDR_W = 12,
    parameter int WAYS   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_req_write,
    input logic              cpu_resp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              lk_hit,
    input logic [WAYS-1:0]   hit_way
);
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_ready && !cpu_req_write && lk_hit |=> cpu_resp_valid); // R2
    AST_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_write |-> mem_req_addr[3:0] == 4'd0); // R3
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cpu_req_ready); // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                            && $stable(mem_req_write)); // R6
    AST_WRITE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_ready && cpu_req_write |=> mem_req_valid && mem_req_write); // R7
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_way)); // R10
endmodule

bind sa_cache sa_cache_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_req_write  (cpu_req_write),
    .cpu_resp_valid (cpu_resp_valid),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_write  (mem_req_write),
    .mem_req_addr   (mem_req_addr),
    .lk_hit         (lk_hit),
    .hit_way        (hit_way)
);

// File: tb/test_sa_cache.sv
`timescale 1ns/1ps
module test_sa_cache;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        cv = 1'b0, cw = 1'b0;
    logic [11:0] ca = '0;
    logic [31:0] cd = '0;
    logic        crdy [2], rv [2], mv [2], mr [2], mw [2], sv [2];
    logic [31:0] rd [2], mwd [2], sd [2];
    logic [11:0] ma [2];

    sa_cache #(.ADDR_W(12), .SET_BITS(1), .WAYS(1)) i_sa_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req_valid(cv), .cpu_req_ready(crdy[0]),
        .cpu_req_write(cw), .cpu_req_addr(ca), .cpu_req_wdata(cd),
        .cpu_resp_valid(rv[0]), .cpu_resp_rdata(rd[0]), .mem_req_valid(mv[0]),
        .mem_req_ready(mr[0]), .mem_req_write(mw[0]), .mem_req_addr(ma[0]),
        .mem_req_wdata(mwd[0]), .mem_rsp_valid(sv[0]), .mem_rsp_data(sd[0]));

    sa_cache #(.ADDR_W(12), .SET_BITS(0), .WAYS(2)) i_sa_cache_2w (
        .clk(clk), .rst_n(rst_n), .cpu_req_valid(cv), .cpu_req_ready(crdy[1]),
        .cpu_req_write(cw), .cpu_req_addr(ca), .cpu_req_wdata(cd),
        .cpu_resp_valid(rv[1]), .cpu_resp_rdata(rd[1]), .mem_req_valid(mv[1]),
        .mem_req_ready(mr[1]), .mem_req_write(mw[1]), .mem_req_addr(ma[1]),
        .mem_req_wdata(mwd[1]), .mem_rsp_valid(sv[1]), .mem_rsp_data(sd[1]));

    int checks = 0, failures = 0, cycles = 0, tick = 0;
    logic [31:0] ram [1024];
    logic [31:0] shadow [1024];
    int beats [2], base [2], rdreq [2], wrreq [2], last_ra [2], last_wa [2];
    bit pend [2], pend_w [2];
    int pend_a [2];
    logic [31:0] pend_d [2], last_wd [2];
    int lines [4][$];   // per copy and set, most recent block first

    task automatic chk(input bit ok, input string rq, input string what, input int i,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s copy%0d %s: actual=%0h expected=%0h", rq, i, what, act, exp);
        end
    endtask

    function automatic int qsel(input int i, input int a);
        return (i == 0) ? ((a >> 4) & 1) : 2;
    endfunction

    function automatic bit m_hit(input int i, input int a);
        int s = qsel(i, a);
        foreach (lines[s][k]) if (lines[s][k] == (a >> 4)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic m_touch(input int i, input int a);
        int s = qsel(i, a);
        for (int k = lines[s].size() - 1; k >= 0; k--)
            if (lines[s][k] == (a >> 4)) lines[s].delete(k);
        lines[s].push_front(a >> 4);
        if (lines[s].size() > ((i == 0) ? 1 : 2)) void'(lines[s].pop_back());
    endtask

    // memory model and per-clock comparison
    always @(negedge clk) begin
        tick++;
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                beats[i] = 0; pend[i] = 1'b0; sv[i] = 1'b0; mr[i] = 1'b0; sd[i] = '0;
            end else begin
                if (pend[i]) begin
                    pend[i] = 1'b0;
                    if (pend_w[i]) ram[pend_a[i] >> 2] = pend_d[i];
                    else begin beats[i] = 4; base[i] = pend_a[i] >> 2; end
                end
                if (beats[i] > 0 && (tick % 3) != 1) begin
                    sv[i] = 1'b1;
                    sd[i] = ram[base[i] + 4 - beats[i]];
                    beats[i]--;
                end else begin
                    sv[i] = 1'b0;
                end
                mr[i] = (tick % 2) == 0;
                if (mv[i]) chk(!crdy[i], "R4", "ready while memory busy", i, crdy[i], 0);
                if (mv[i] && mr[i]) begin
                    pend[i] = 1'b1; pend_w[i] = mw[i]; pend_a[i] = int'(ma[i]); pend_d[i] = mwd[i];
                    if (mw[i]) begin wrreq[i]++; last_wa[i] = int'(ma[i]); last_wd[i] = mwd[i]; end
                    else begin rdreq[i]++; last_ra[i] = int'(ma[i]); end
                end
            end
        end
    end

    task automatic access(input bit wr, input int a, input logic [31:0] d, input string rq);
        bit ph [2], done [2];
        int r0 [2], w0 [2], lat [2];
        logic [31:0] got [2];
        for (int i = 0; i < 2; i++) begin
            ph[i] = m_hit(i, a); r0[i] = rdreq[i]; w0[i] = wrreq[i];
            done[i] = 1'b0; lat[i] = 0; got[i] = '0;
        end
        @(negedge clk);
        for (int i = 0; i < 2; i++) chk(crdy[i], rq, "idle before request", i, crdy[i], 1);
        cv = 1'b1; cw = wr; ca = a[11:0]; cd = d;
        @(negedge clk);
        cv = 1'b0;
        for (int cyc = 1; cyc < 300; cyc++) begin
            for (int i = 0; i < 2; i++)
                if (!done[i] && rv[i]) begin done[i] = 1'b1; lat[i] = cyc; got[i] = rd[i]; end
            if (done[0] && done[1]) break;
            @(negedge clk);
        end
        for (int i = 0; i < 2; i++) begin
            chk(done[i], rq, "response seen", i, done[i], 1);
            if (!wr) begin
                chk(got[i] == shadow[a >> 2], rq, "read data (R2/R4)", i, got[i], shadow[a >> 2]);
                if (ph[i]) begin
                    chk(lat[i] == 1, rq, "hit latency R2", i, lat[i], 1);
                    chk(rdreq[i] == r0[i], rq, "no fetch on hit R2", i, rdreq[i] - r0[i], 0);
                end else begin
                    chk(rdreq[i] == r0[i] + 1, rq, "one fetch on miss R3", i, rdreq[i] - r0[i], 1);
                    chk(last_ra[i] == (a & ~15), rq, "block base R3", i, last_ra[i], a & ~15);
                    chk(lat[i] >= 6, rq, "refill latency R4", i, lat[i], 6);
                end
            end else begin
                chk(wrreq[i] == w0[i] + 1, rq, "write forwarded R7", i, wrreq[i] - w0[i], 1);
                chk(last_wa[i] == (a & ~3), rq, "write address R7", i, last_wa[i], a & ~3);
                chk(last_wd[i] == d, rq, "write data R7", i, last_wd[i], d);
                chk(rdreq[i] == r0[i], rq, "no fetch on write R9", i, rdreq[i] - r0[i], 0);
            end
            if (!wr || ph[i]) m_touch(i, a);
        end
        if (wr) shadow[a >> 2] = d;
    endtask

    task automatic do_reset();
        cv = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(crdy[i] == 1'b1, "R12", "ready in reset", i, crdy[i], 1);
            chk(rv[i] == 1'b0, "R12", "no response in reset", i, rv[i], 0);
            chk(mv[i] == 1'b0, "R12", "no memory request in reset", i, mv[i], 0);
        end
        for (int s = 0; s < 4; s++) lines[s].delete();
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        for (int k = 0; k < 1024; k++) begin
            ram[k] = {16'hC0DE, 16'(k)} ^ (32'(k) * 32'h9E37);
            shadow[k] = ram[k];
        end
        do_reset();
        access(0, 'h008, 0, "R3");           // miss in both
        access(0, 'h00C, 0, "R5");           // rest of block now valid
        access(0, 'h000, 0, "R5");
        access(0, 'h014, 0, "R1");           // next block, other set / other way
        access(0, 'h004, 0, "R1");           // both blocks resident together
        access(0, 'h028, 0, "R10");          // two-way evicts block 1, direct evicts block 0
        access(0, 'h018, 0, "R10");          // direct hits, two-way misses
        access(0, 'h000, 0, "R11");          // direct-mapped conflict miss
        access(1, 'h024, 32'hDEAD_0024, "R9");
        access(0, 'h024, 0, "R9");           // no allocation on write miss
        access(1, 'h028, 32'hBEEF_0028, "R8");
        access(0, 'h028, 0, "R8");           // hit with updated word
        do_reset();
        access(0, 'h028, 0, "R12");          // valid flags cleared
        seed = 32'h1234_5678;
        for (int n = 0; n < 80; n++) begin
            int a;
            seed = seed * 1103515245 + 12345;
            a = (((seed >>> 9) & 7) << 4) | (((seed >>> 5) & 3) << 2);
            access(((seed >>> 20) & 3) == 0, a, 32'(seed), "R1");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule